// File: doc/BRIEF.md
# Interleaved I/Q Sample Splitter

This block receives one 12-bit word stream that carries in-phase and quadrature samples alternately, at twice the rate of each channel. It separates the stream into an I/Q pair that it presents on two output buses together, with one strobe for each completed pair. Downstream logic sees one pair every two clocks.

An alignment input, `align_in`, fixes which word belongs to I. The input may be a free-running synchronous square wave or a single pulse with no timing relation to the clock. It passes through a two-stage synchronizer and an edge detector. The data path carries the same delay, so the word sampled at the clock edge where the input is first seen high is the word that becomes I. After that the words alternate between I and Q with no further help from the alignment input. If a rising edge arrives while an I word is waiting for its Q partner, that I word is dropped and alignment restarts.

Top module: `iq_deinterleave`

## Requirements
- R1: While `rst_n` is low, `i_out` and `q_out` are 0 and `pair_valid` is 0.
- R2: The word on `din` at the clock edge where `align_in` is first sampled high, after having been sampled low, becomes I, and the word at the next edge becomes Q of the same pair.
- R3: With no further rising edge on `align_in`, later words alternate strictly: each even word after the I word is I and each odd word is Q.
- R4: A rising edge on `align_in` while an I word waits for its Q partner discards that I word, and the word sampled at that edge starts a new pair as I.
- R5: A rising edge that arrives when the next word is already due to be I leaves the sequence of pairs unchanged, so a synchronous alignment square wave of period four clocks gives the same pairs as no alignment activity.
- R6: After reset, and before any rising edge on `align_in`, the first word sampled after reset release is I and pairing proceeds from there.
- R7: `pair_valid` is high for exactly one cycle per completed pair and is never high in two consecutive cycles.
- R8: A pair appears on the outputs, with `pair_valid` high, in the cycle after the second clock edge following the edge that sampled its Q word.
- R9: `i_out` and `q_out` hold their values in every cycle in which `pair_valid` is low.
- R10: Holding `align_in` high over many cycles has no effect beyond its single rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all words are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 12 | Interleaved sample word |
| align_in | input | 1 | Alignment marker; may change at any time |
| i_out | output | 12 | In-phase half of the latest pair |
| q_out | output | 12 | Quadrature half of the latest pair |
| pair_valid | output | 1 | One-cycle strobe for a new pair |

## Verification
The assertions assume that `align_in` holds each level for at least one clock edge, so that the synchronizer cannot report two rising edges less than two cycles apart. The stimulus changes `align_in` and `din` only on the falling clock edge, and every level it drives lasts at least one full cycle. The stimulus mixes directed phases with random toggling: quiet startup, a mid-pair edge, a long high level, an aligned edge, and a period-four square wave.

// File: rtl/iq_deinterleave.sv
module iq_deinterleave #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         align_in,
  output logic [W-1:0] i_out,
  output logic [W-1:0] q_out,
  output logic         pair_valid
);

  logic         s1, s2, s3;
  logic [W-1:0] d1, d2, i_hold;
  logic         v1, v2;
  logic         want_q;
  logic         rise;

  assign rise = s2 & ~s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
      d1 <= '0;
      d2 <= '0;
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else begin
      s1 <= align_in;
      s2 <= s1;
      s3 <= s2;
      d1 <= din;
      d2 <= d1;
      v1 <= 1'b1;
      v2 <= v1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want_q     <= 1'b0;
      i_hold     <= '0;
      i_out      <= '0;
      q_out      <= '0;
      pair_valid <= 1'b0;
    end else begin
      pair_valid <= 1'b0;
      if (v2) begin
        if (rise || !want_q) begin
          i_hold <= d2;
          want_q <= 1'b1;
        end else begin
          i_out      <= i_hold;
          q_out      <= d2;
          pair_valid <= 1'b1;
          want_q     <= 1'b0;
        end
      end
    end
  end

  // R7
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |=> !pair_valid);

  // R9
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_valid |-> ($stable(i_out) && $stable(q_out)));

  // R4
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !pair_valid);

  // R2
  edge_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && v2) |-> ##2 pair_valid);

  // R6
  fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !v2 |=> !pair_valid);

endmodule

// File: tb/test_iq_deinterleave.sv
module test_iq_deinterleave;
  localparam int N = 2000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] din = '0;
  logic        align_in = 1'b0;
  logic [11:0] i_out, q_out;
  logic        pair_valid;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [11:0] exp_i [N];
  logic [11:0] exp_q [N];
  logic        exp_v [N];

  iq_deinterleave i_iq_deinterleave (
    .clk(clk), .rst_n(rst_n), .din(din), .align_in(align_in),
    .i_out(i_out), .q_out(q_out), .pair_valid(pair_valid)
  );

  always #2.5 clk = ~clk;

  function automatic logic sel_pattern(input int n, input logic cur, input int r);
    if (n < 11)  return 1'b0;
    if (n < 41)  return 1'b1;
    if (n < 61)  return 1'b0;
    if (n < 80)  return 1'b1;
    if (n < 100) return 1'b0;
    if (n < 300) return ((n % 4) < 2);
    return (r % 8 == 0) ? ~cur : cur;
  endfunction

  function automatic string tag_of(input int n);
    if (n < 11)  return "R6 R8";
    if (n < 21)  return "R4 R8";
    if (n < 61)  return "R10 R3";
    if (n < 100) return "R2 R8";
    if (n < 300) return "R5 R3";
    return "R3 R9";
  endfunction

  task automatic check(input string tag, input logic v, input logic [11:0] ei,
                       input logic [11:0] eq);
    tests++;
    if (pair_valid !== v || i_out !== ei || q_out !== eq) begin
      fails++;
      $display("FAIL %s: got v=%0b i=%h q=%h, expected v=%0b i=%h q=%h",
               tag, pair_valid, i_out, q_out, v, ei, eq);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #100000;
    fails++;
    tests++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    logic m_prev, m_wq, m_v, s;
    logic [11:0] m_hold, m_i, m_q, d;
    int r;
    r = $urandom(32'h5eed_1234);
    m_prev = 0; m_wq = 0; m_hold = '0; m_i = '0; m_q = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    check("R1", 1'b0, 12'h000, 12'h000);
    rst_n = 1'b1;
    s = 1'b0;
    for (int n = 0; n < N; n++) begin
      r = $urandom;
      s = sel_pattern(n, s, r);
      d = 12'($urandom);
      align_in = s;
      din = d;
      m_v = 1'b0;
      if ((s && !m_prev) || !m_wq) begin
        m_hold = d;
        m_wq = 1'b1;
      end else begin
        m_i = m_hold;
        m_q = d;
        m_v = 1'b1;
        m_wq = 1'b0;
      end
      m_prev = s;
      exp_v[n] = m_v; exp_i[n] = m_i; exp_q[n] = m_q;
      @(posedge clk);
      @(negedge clk);
      if (n >= 2) check(tag_of(n - 2), exp_v[n-2], exp_i[n-2], exp_q[n-2]);
      else        check("R6 R1", 1'b0, 12'h000, 12'h000);
    end
    finish_run();
  end
endmodule